// File: doc/BRIEF.md
# Serial Character Transmitter with Ready and Complete Flags

This block sends one character at a time on a single serial line. Software programs a control register, polls or takes an interrupt from a status register, and writes characters to a data register that cannot be read back. Each character goes out as a low start bit, then 8 data bits (or 9 when the long-character mode is on), least significant bit first, then a high stop bit. The line moves one bit per pulse on `bit_tick`, which a separate baud divider supplies.

Two status flags track progress. The ready flag shows that the data register can take a new character. The complete flag shows that the line has nothing left to send. A data write is taken only while the ready flag is set. A character written while the transmitter is disabled waits in the data register, and a later write replaces it. The waiting character goes out once the enable bit is set. The interrupt request combines each flag with its own enable bit.

Register map (address on `wr_addr` / `rd_addr`): 0 is control, 1 is status (read only), 2 is data (write only, reads 0), and 3 reads 0. Control bits: [0] transmit enable, [1] long-character mode, [2] ninth data bit, [3] break, [4] ready-interrupt enable, [5] complete-interrupt enable, [7:6] spare and read back. Status bits: [0] ready, [1] complete, [7:2] always 0.

Top module: `sci_tx`

## Requirements
- R1: After reset the status register reads 0x03 (ready and complete set), the control register reads 0x00, `tx_line` is 1 and `irq` is 0.
- R2: A write to address 2 while ready is 0 is dropped. It does not change the character in flight, and no further frame follows the current one.
- R3: A data write while ready is 1, enable is 1 and no frame is running starts a frame at that clock edge. From the next cycle, status reads 0x00 and `tx_line` carries the start bit (0).
- R4: A data write while enable is 0 leaves status at 0x03 and the line idle. A second such write replaces the held character. Setting enable later starts the frame with the held character in the cycle after the control write takes effect.
- R5: In 8-bit mode (control bit 1 = 0) a frame is start bit 0, data bits 0..7, then stop bit 1. Each bit after the start bit is held from one `bit_tick` to the next, so the frame ends on the 10th tick.
- R6: In 9-bit mode (control bit 1 = 1) control bit 2, sampled when the frame starts, is sent after data bit 7, and the frame ends on the 11th tick.
- R7: On the clock edge where the final tick of a frame is taken, ready and complete are both set again.
- R8: Writes to address 1 change neither the status nor the control register.
- R9: `irq` equals (control bit 4 AND ready) OR (control bit 5 AND complete).
- R10: While control bit 3 is set, `tx_line` is 0. With no frame running and break clear, `tx_line` is 1.
- R11: Address 0 reads back all 8 control bits as written. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| tx_line | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the first clock edge it spans. A data write that starts a frame shows cleared flags and the start bit one cycle later. A held character starts one cycle after the enabling control write, because the start decision sees the registered enable. A `bit_tick` moves the line, and on the last bit it sets the flags, at the edge where the tick is sampled. `rd_data` and `irq` follow combinationally. The reference model advances at each rising edge using the inputs held since the previous falling edge. Every output is compared against it at the falling edge, and the directed checks read status after the same one-edge latencies.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // control register layout, MSB first
  typedef struct packed {
    logic [1:0] spare;
    logic       done_ie;
    logic       ready_ie;
    logic       brk;
    logic       bit9;
    logic       len9;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/sci_tx_regs.sv
module sci_tx_regs
  import sci_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ready,
  input  logic              done,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  rd_data
);

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we = wr_en && (wr_addr == REG_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: rd_data = ctrl_q;
      REG_STAT: rd_data = {{(REG_W-2){1'b0}}, done, ready};
      default:  rd_data = '0;
    endcase
  end

  // R8: status writes leave the control register alone
  p_stat_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_STAT) |=> $stable(ctrl_q));

  // R11: control readback matches the last write
  p_ctrl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_CTRL) |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/sci_tx_ctl.sv
module sci_tx_ctl
  import sci_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en,
  input  logic              ready_ie,
  input  logic              done_ie,
  input  logic              busy,
  input  logic              frame_end,
  output logic              ready,
  output logic              done,
  output logic              start,
  output logic [DATA_W-1:0] start_data,
  output logic              irq
);

  logic              ready_q, ready_d;
  logic              done_q, done_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              accept;

  assign accept     = data_wr && ready_q;
  assign start      = en && !busy && (pend_q || accept);
  assign start_data = accept ? wr_data : hold_q;

  always_comb begin
    ready_d = ready_q;
    done_d  = done_q;
    pend_d  = pend_q;
    hold_d  = hold_q;
    if (accept) hold_d = wr_data;
    if (start) begin
      ready_d = 1'b0;
      done_d  = 1'b0;
      pend_d  = 1'b0;
    end else begin
      if (accept)    pend_d  = 1'b1;
      if (frame_end) begin
        ready_d = 1'b1;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      done_q  <= 1'b1;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      ready_q <= ready_d;
      done_q  <= done_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  assign ready = ready_q;
  assign done  = done_q;
  assign irq   = (ready_ie && ready_q) || (done_ie && done_q);

  // R2: a write while not ready does not touch the held character
  p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ready_q) |=> $stable(hold_q));

  // R3: starting a frame clears both flags
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready_q && !done_q));

  // R3: ready is never set while the shifter runs
  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready_q);

  // R4: a held character only exists while ready
  p_pend_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ready_q);

  // R7: end of frame restores both flags
  p_end_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (ready_q && done_q));

  // R9: a request needs at least one flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ready_q || done_q));

endmodule

// File: rtl/sci_tx_shift.sv
module sci_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              len9,
  input  logic              bit9,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              line_bit,
  output logic              frame_end
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FRAME_W - 2);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   last_q, last_d;
  logic               busy_q, busy_d;
  logic               step;

  assign step      = busy_q && tick;
  assign frame_end = step && (cnt_q == last_q);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = {1'b1, (len9 ? bit9 : 1'b1), load_data, 1'b0};
      cnt_d  = '0;
      last_d = len9 ? LAST_LONG : LAST_SHORT;
      busy_d = 1'b1;
    end else if (step) begin
      sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      cnt_d = cnt_q + CNT_W'(1);
      if (frame_end) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      last_q <= LAST_SHORT;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign line_bit = busy_q ? sh_q[0] : 1'b1;

  // R5: bit counter stays within the latched frame length
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_q));

  // R5: a load puts the start bit on the line next cycle
  p_start_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !line_bit));

  // R7: the shifter is idle after the final tick
  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy_q);

endmodule

// File: rtl/sci_tx.sv
module sci_tx
  import sci_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              tx_line,
  output logic              irq
);

  logic        rs_meta_q, rs_sync_q;
  logic        rst_sync_n;
  ctrl_t       ctrl;
  logic        ready, done, start, busy, line_bit, frame_end, data_wr;
  logic [DATA_W-1:0] start_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end
  assign rst_sync_n = rs_sync_q;

  assign data_wr = wr_en && (wr_addr == REG_DATA);

  sci_tx_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .ready   (ready),
    .done    (done),
    .ctrl    (ctrl),
    .rd_data (rd_data)
  );

  sci_tx_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .data_wr    (data_wr),
    .wr_data    (wr_data[DATA_W-1:0]),
    .en         (ctrl.en),
    .ready_ie   (ctrl.ready_ie),
    .done_ie    (ctrl.done_ie),
    .busy       (busy),
    .frame_end  (frame_end),
    .ready      (ready),
    .done       (done),
    .start      (start),
    .start_data (start_data),
    .irq        (irq)
  );

  sci_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (bit_tick),
    .load      (start),
    .len9      (ctrl.len9),
    .bit9      (ctrl.bit9),
    .load_data (start_data),
    .busy      (busy),
    .line_bit  (line_bit),
    .frame_end (frame_end)
  );

  assign tx_line = ctrl.brk ? 1'b0 : line_bit;

  // R10: break holds the line low
  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl.brk |-> !tx_line);

  // R10: with both flags set and no break, the line idles high
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && done && !ctrl.brk) |-> tx_line);

endmodule

// File: tb/sci_tx_tb.sv
`timescale 1ns/100ps
module sci_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd1;
  logic [7:0] rd_data;
  logic       tx_line, irq;

  int n_tot = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sci_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_line(tx_line), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bit tick: one pulse every 4 cycles
  int tk = 0;
  always @(negedge clk) begin
    #1;
    tk = (tk + 1) % 4;
    bit_tick = (tk == 3);
  end

  // reference model
  int         m_rs = 0;
  logic [7:0] m_ctrl = 8'h00;
  bit         m_ready = 1, m_done = 1, m_pend = 0, m_busy = 0, m_long = 0;
  logic [7:0] m_hold = 8'h00;
  bit         m_q[$];

  always @(posedge clk) begin
    bit in_rst, acc, st;
    logic [7:0] ch;
    in_rst = (m_rs < 2) || !rst_n;
    if (in_rst) begin
      m_ctrl = 8'h00; m_ready = 1; m_done = 1; m_pend = 0; m_busy = 0;
      m_hold = 8'h00; m_q.delete();
    end else begin
      acc = wr_en && wr_addr == 2'd2 && m_ready;
      st  = m_ctrl[0] && !m_busy && (m_pend || acc);
      ch  = acc ? wr_data : m_hold;
      if (m_busy && bit_tick) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_busy = 0; m_ready = 1; m_done = 1; end
      end
      if (acc) m_hold = wr_data;
      if (st) begin
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(ch[i]);
        if (m_ctrl[1]) m_q.push_back(m_ctrl[2]);
        m_q.push_back(1'b1);
        m_long = m_ctrl[1];
        m_busy = 1; m_ready = 0; m_done = 0; m_pend = 0;
      end else if (acc) m_pend = 1;
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data;
    end
    if (!rst_n) m_rs = 0; else if (m_rs < 2) m_rs++;
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    logic el;
    logic [7:0] er;
    if (!finished) begin
      el = m_ctrl[3] ? 1'b0 : (m_busy ? m_q[0] : 1'b1);
      if (m_ctrl[3])   chk("R10 line", tx_line, el);
      else if (m_long) chk("R6 line", tx_line, el);
      else             chk("R5 line", tx_line, el);
      chk("R9 irq", irq, (m_ctrl[4] & m_ready) | (m_ctrl[5] & m_done));
      case (rd_addr)
        2'd0: er = m_ctrl;
        2'd1: er = {6'd0, m_done, m_ready};
        default: er = 8'h00;
      endcase
      chk("R11 rd_data", rd_data, er);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #0.5;
    d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int lows;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 8'h03);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 line", tx_line, 1'b1);
    chk("R1 irq", irq, 1'b0);

    // R3 immediate start, R2 write while busy dropped, R7 flags return
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hA5);
    rd(2'd1, v); chk("R3 status after start", v, 8'h00);
    chk("R3 start bit", tx_line, 1'b0);
    wr(2'd2, 8'h3C);
    cyc(60);
    rd(2'd1, v); chk("R7 status after frame", v, 8'h03);
    lows = 0;
    for (int i = 0; i < 40; i++) begin cyc(1); if (!tx_line) lows++; end
    chk("R2 no second frame", lows, 0);

    // R8 status write ignored
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R8 status kept", v, 8'h03);
    rd(2'd0, v); chk("R8 ctrl kept", v, 8'h01);

    // R4 held character, replaced, sent on enable
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h11);
    wr(2'd2, 8'h22);
    rd(2'd1, v); chk("R4 status while held", v, 8'h03);
    cyc(10);
    chk("R4 line idle while held", tx_line, 1'b1);
    wr(2'd0, 8'h01);
    cyc(1);
    rd(2'd1, v); chk("R4 start on enable", v, 8'h00);
    cyc(60);

    // R6 nine-bit frame with ninth bit set, then clear
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h80);
    cyc(60);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'hFF);
    cyc(60);
    rd(2'd1, v); chk("R6 flags after long frame", v, 8'h03);

    // R9 interrupt combinations
    wr(2'd0, 8'h11);
    chk("R9 ready irq", irq, 1'b1);
    wr(2'd0, 8'h21);
    wr(2'd2, 8'h5A);
    chk("R9 irq low in frame", irq, 1'b0);
    cyc(60);
    chk("R9 complete irq", irq, 1'b1);
    wr(2'd0, 8'h01);
    chk("R9 irq disabled", irq, 1'b0);

    // R10 break
    wr(2'd0, 8'h09);
    chk("R10 break low", tx_line, 1'b0);
    wr(2'd0, 8'h01);
    chk("R10 idle high", tx_line, 1'b1);

    // R11 readback
    wr(2'd0, 8'hC1);
    rd(2'd0, v); chk("R11 ctrl readback", v, 8'hC1);
    rd(2'd2, v); chk("R11 data reads zero", v, 8'h00);
    rd(2'd3, v); chk("R11 spare reads zero", v, 8'h00);
    cyc(4);
    finish_up();
  end

endmodule